// File: doc/BRIEF.md
# Edge-Latched Read-Only Memory Read Port

This block is a synthesizable model of a 2048-word by 8-bit read-only memory with a read port suited to a multiplexed address/data processor bus. The chip-enable (`ce_n`) is active low. When the block sees it go from high to low, it captures the 11-bit address into an internal register. After that capture the address bus is free to carry other traffic, and later address changes have no effect until the next high-to-low transition. A separate active-low output-enable (`oe_n`) decides whether the data bus is driven. A program-enable input (`prog_en`) must be held high for any read to be driven.

The storage is a square matrix of 128 by 128 bits. The upper seven address bits select a row. Within each output bit's group of 16 columns, the lower four address bits pick one column. The contents are computed by a constant function of the address, so no file is loaded. The high-impedance state of a three-state bus is modelled by a `q_drive` flag placed next to the data word. This flag acts as the valid qualifier of the read stream. A read bus has no back-pressure, so there is no ready signal: a word is valid in every cycle in which `q_drive` is high.

All control inputs are sampled on the rising edge of `clk`. The effect of a sample appears on the outputs after that same edge.

Top module: `edge_latch_rom`

## Requirements
- R1: While `rst_n` is low, `q_drive` is 0 and `q` is 0. The latched address resets to 0 and the previous chip-enable state resets to high.
- R2: An edge sample that sees `ce_n` low, when the previous sample saw it high, loads `addr` into the address register. The output reflects the new address right after that edge.
- R3: While `ce_n` stays low, changes on `addr` do not alter the word presented on `q`. Only a new high-to-low transition of `ce_n` starts a new access.
- R4: After an edge that samples `ce_n` high, `q_drive` is 0, whatever the value of `oe_n`.
- R5: After an edge that samples `ce_n` low and `oe_n` high, `q_drive` is 0. The latched address is kept, so driving `oe_n` low again shows the same word.
- R6: After an edge that samples `ce_n` low, `oe_n` low and `prog_en` high, `q_drive` is 1 and `q` carries the word at the latched address.
- R7: After an edge that samples `prog_en` low, `q_drive` is 0. The address capture is unaffected.
- R8: The word stored at address a is a[7:0] XOR 8'h5A XOR {5'b0, a[10:8]}.
- R9: Address bits [10:4] select one of 128 rows. Output bit b is taken from row column b*16 + a[3:0].
- R10: Whenever `q_drive` is 0, `q` reads all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip enable; its falling transition latches the address |
| oe_n | input | 1 | Active-low output enable |
| prog_en | input | 1 | Must be high for reads to be driven |
| addr | input | 11 | Word address |
| q | output | 8 | Read data, zero when not driven |
| q_drive | output | 1 | High when the data bus is driven (valid) |

## Verification
The bench builds the block with its default parameters: 11 address bits, 8 data bits, 4 column bits and a 128-row matrix. These sizes are small enough that every one of the 2048 addresses can be latched and read back. That reaches every row select and every column select of each output bit. Between reads the bench also holds `ce_n` low while moving the address, toggles `oe_n`, and drops `prog_en`, so the enable table and the hold of the latched address are both exercised.

// File: rtl/edge_latch_rom_pkg.sv
package edge_latch_rom_pkg;
  localparam int AW   = 11;
  localparam int DW   = 8;
  localparam int CB   = 4;
  localparam logic [DW-1:0] SEED = 8'h5A;

  // Word content: seed, with address bit i folded onto data bit i mod DW
  function automatic logic [DW-1:0] rom_word(input logic [AW-1:0] a);
    logic [DW-1:0] w;
    w = SEED;
    for (int i = 0; i < AW; i++) w[i % DW] = w[i % DW] ^ a[i];
    return w;
  endfunction
endpackage

// File: rtl/elr_addr_latch.sv
module elr_addr_latch #(
  parameter int AW = edge_latch_rom_pkg::AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_q
);
  logic ce_prev;
  logic fall;

  assign fall = ce_prev & ~ce_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_prev <= 1'b1;
      addr_q  <= '0;
    end else begin
      ce_prev <= ce_n;
      if (fall) addr_q <= addr_in;
    end
  end

  // R3: without a high-to-low transition the latched address holds
  a_r3_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    !(ce_prev && !ce_n) |=> $stable(addr_q));
  // R2: a transition captures the bus address
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_prev && !ce_n) |=> (addr_q == $past(addr_in)));
endmodule

// File: rtl/elr_row_decode.sv
module elr_row_decode #(
  parameter int AW = edge_latch_rom_pkg::AW,
  parameter int DW = edge_latch_rom_pkg::DW,
  parameter int CB = edge_latch_rom_pkg::CB,
  localparam int RB   = AW - CB,
  localparam int COLS = 1 << CB,
  localparam int RW   = DW * COLS
) (
  input  logic [RB-1:0] row_idx,
  output logic [RW-1:0] row_bits
);
  // Column b*COLS+c of a row holds bit b of word {row, c}
  for (genvar b = 0; b < DW; b++) begin : g_bit
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [DW-1:0] w;
      always_comb begin
        w = edge_latch_rom_pkg::rom_word({row_idx, CB'(c)});
        row_bits[b*COLS + c] = w[b];
      end
    end
  end
endmodule

// File: rtl/elr_col_select.sv
module elr_col_select #(
  parameter int DW = edge_latch_rom_pkg::DW,
  parameter int CB = edge_latch_rom_pkg::CB,
  localparam int COLS = 1 << CB,
  localparam int RW   = DW * COLS
) (
  input  logic [RW-1:0] row_bits,
  input  logic [CB-1:0] col,
  output logic [DW-1:0] data
);
  for (genvar b = 0; b < DW; b++) begin : g_out
    logic [COLS-1:0] grp;
    assign grp     = row_bits[b*COLS +: COLS];
    assign data[b] = grp[col];
  end
endmodule

// File: rtl/elr_out_gate.sv
module elr_out_gate #(
  parameter int DW = edge_latch_rom_pkg::DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          prog_en,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] q,
  output logic          q_drive
);
  logic drive_r;

  always_ff @(posedge clk) begin
    if (!rst_n) drive_r <= 1'b0;
    else        drive_r <= ~ce_n & ~oe_n & prog_en;
  end

  assign q_drive = drive_r;
  assign q       = drive_r ? data_in : '0;

  // R4: chip disabled leaves the bus undriven
  a_r4_ce_off: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !q_drive);
  // R5: output enable high leaves the bus undriven
  a_r5_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> !q_drive);
  // R7: program enable low blocks the read
  a_r7_prog_off: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_en |=> !q_drive);
  // R6: all enables active drive the bus
  a_r6_drive_on: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && prog_en) |=> q_drive);
endmodule

// File: rtl/edge_latch_rom.sv
module edge_latch_rom #(
  parameter int AW = edge_latch_rom_pkg::AW,
  parameter int DW = edge_latch_rom_pkg::DW,
  parameter int CB = edge_latch_rom_pkg::CB,
  localparam int RB = AW - CB,
  localparam int RW = DW * (1 << CB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          prog_en,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] q,
  output logic          q_drive
);
  logic [AW-1:0] addr_q;
  logic [RW-1:0] row_bits;
  logic [DW-1:0] word;

  elr_addr_latch #(.AW(AW)) u_latch (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .addr_in(addr), .addr_q(addr_q)
  );

  elr_row_decode #(.AW(AW), .DW(DW), .CB(CB)) u_row (
    .row_idx(addr_q[AW-1 -: RB]), .row_bits(row_bits)
  );

  elr_col_select #(.DW(DW), .CB(CB)) u_col (
    .row_bits(row_bits), .col(addr_q[CB-1:0]), .data(word)
  );

  elr_out_gate #(.DW(DW)) u_gate (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .prog_en(prog_en),
    .data_in(word), .q(q), .q_drive(q_drive)
  );

  // R10: an undriven bus reads zero
  a_r10_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !q_drive |-> (q == '0));
endmodule

// File: tb/edge_latch_rom_tb_top.sv
module edge_latch_rom_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1;
  logic        oe_n = 1'b1;
  logic        prog_en = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0]  q;
  logic        q_drive;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  typedef struct {
    logic       drv;
    logic [7:0] dat;
    string      tag;
  } exp_t;
  exp_t sb[$];

  logic        m_prev = 1'b1;
  logic [10:0] m_addr = '0;

  always #10 clk = ~clk;

  edge_latch_rom dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .prog_en(prog_en),
    .addr(addr), .q(q), .q_drive(q_drive)
  );

  // R8 content, written independently of the design
  function automatic logic [7:0] exp_word(input logic [10:0] a);
    return a[7:0] ^ 8'h5A ^ {5'b0, a[10:8]};
  endfunction

  // Driver: apply one cycle of inputs at the falling clock edge, push expectation
  task automatic step(input logic c, input logic o, input logic p,
                      input logic [10:0] a, input string tag);
    exp_t e;
    @(negedge clk);
    ce_n = c; oe_n = o; prog_en = p; addr = a;
    if (m_prev && !c) m_addr = a;
    m_prev = c;
    e.drv = !c && !o && p;
    e.dat = e.drv ? exp_word(m_addr) : 8'h00;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compare shortly after each rising edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      vecs++;
      if (q_drive !== e.drv || q !== e.dat) begin
        errs++;
        $display("FAIL %s: got drive=%0b q=%02h, expected drive=%0b q=%02h",
                 e.tag, q_drive, q, e.drv, e.dat);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    vecs++;
    if (q_drive !== 1'b0 || q !== 8'h00) begin  // R1
      errs++;
      $display("FAIL R1: got drive=%0b q=%02h, expected drive=0 q=00", q_drive, q);
    end
    rst_n = 1'b1;

    // R2 first access just after reset
    step(1'b0, 1'b0, 1'b1, 11'h123, "R2");
    step(1'b1, 1'b0, 1'b1, 11'h123, "R4");

    // Full sweep: every row and column (R8, R9), idle cycles (R4, R10)
    for (int i = 0; i < 2048; i++) begin
      step(1'b1, 1'b0, 1'b1, 11'(i), (i % 2) ? "R4" : "R10");
      step(1'b0, 1'b0, 1'b1, 11'(i), (i % 2) ? "R8" : "R9");
    end

    // R3: address moves while ce_n stays low
    step(1'b1, 1'b1, 1'b1, 11'h7FF, "R4");
    step(1'b0, 1'b0, 1'b1, 11'h3C5, "R2");
    for (int k = 0; k < 6; k++)
      step(1'b0, 1'b0, 1'b1, 11'(k * 301 + 17), "R3");

    // R5: output enable high keeps the latched address
    step(1'b0, 1'b1, 1'b1, 11'h001, "R5");
    step(1'b0, 1'b1, 1'b1, 11'h6AA, "R5");
    step(1'b0, 1'b0, 1'b1, 11'h055, "R5");

    // R4: ce_n high with oe_n low
    step(1'b1, 1'b0, 1'b1, 11'h055, "R4");
    step(1'b1, 1'b1, 1'b1, 11'h055, "R4");

    // R7: prog_en low blocks drive but not capture
    step(1'b0, 1'b0, 1'b0, 11'h4E1, "R7");
    step(1'b0, 1'b0, 1'b0, 11'h111, "R7");
    step(1'b0, 1'b0, 1'b1, 11'h222, "R7");

    // R6: back-to-back accesses
    for (int k = 0; k < 8; k++) begin
      step(1'b1, 1'b0, 1'b1, 11'(k * 257), "R6");
      step(1'b0, 1'b0, 1'b1, 11'(k * 257), "R6");
    end
    step(1'b1, 1'b1, 1'b1, 11'h000, "R10");

    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule